// File: doc/BRIEF.md
# Time-Multiplexed Fully Connected Neuron Layer

This block evaluates one fully connected layer of a small integer neural network. It holds one multiply-accumulate unit per output neuron. A single index counter steps every unit through the layer inputs in lockstep. On each step the counter picks one input value from a shared multiplexer, and each neuron multiplies that value by its own weight for that input. The product is added into the neuron's private accumulator.

When the last input has been consumed, one more cycle adds each neuron's bias and applies a symmetric saturating activation. The results land in a registered output vector, and a one-cycle completion pulse is raised. Weights and biases are fixed integer parameters in a scaled fixed-point format, where the value one equals 2^Q. The completion pulse can drive the start input of a following layer, so a chain of layers runs one layer at a time. A layer that has finished stays idle until it is started again.

Top module: `mac_layer`

## Requirements
- R1: While reset is low, and just after it is released, `out_vec` is all zeros and both `busy` and `done` are low.
- R2: A `start` sampled high while the layer is idle is accepted, and `in_vec` is captured at that clock edge. Input i occupies bits [i*DW +: DW] as a two's complement value. `busy` is high from the next cycle until the result appears.
- R3: `done` is high for exactly one cycle, N_IN+1 rising edges after the accepting edge. `busy` falls on that same edge, and `done` and `busy` are never high together.
- R4: For neuron j, the pre-activation sum is y_j = B[j] + sum over i of W[j][i]*x_i. W[j][i] is the signed DW-bit field at WEIGHTS[(j*N_IN+i)*DW +: DW]. B[j] is the signed 2*DW-bit field at BIASES[j*2*DW +: 2*DW] and uses the product scale 2^(2Q).
- R5: The sum is rescaled with an arithmetic right shift by Q, which rounds toward minus infinity. For example, -56 with Q=4 gives -4.
- R6: The rescaled value is clamped to the range [-2^Q, +2^Q]. Neuron j's result sits in `out_vec[j*DW +: DW]` as two's complement.
- R7: A `start` that arrives while `busy` is high is ignored. It neither alters the running result nor triggers a second computation.
- R8: Changes on `in_vec` while `busy` is high do not affect the result.
- R9: `out_vec` changes only on the edge that raises `done`. Between computations it holds its value whatever `in_vec` does.
- R10: A `start` sampled in the same cycle that `done` is high is accepted, so layers can run back to back.
- R11: The accumulator never overflows, even for inputs and weights at the extremes of the DW-bit range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a layer evaluation |
| in_vec | input | N_IN*DW | Packed signed layer inputs |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_vec | output | N_OUT*DW | Packed signed activated neuron outputs |

## Verification
The bench builds the layer with four inputs, three neurons, 8-bit data and Q=4, so the value one is 16 and the clamp limits are ±16. These weights include values at both ends of the 8-bit range. With them, a handful of input vectors reach both clamp limits, a negative non-integer quotient that shows the floor rounding, and extreme sums that fill the accumulator's guard bits. The short input count keeps each run at five cycles. This leaves room for starts during a run, input changes mid-run and back-to-back starts on the completion cycle.

// File: rtl/mac_layer_pkg.sv
package mac_layer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

endpackage

// File: rtl/mac_layer_ctrl.sv
module mac_layer_ctrl
    import mac_layer_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int IW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          load,
    output logic          acc_en,
    output logic          fin,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N_IN - 1);

    typedef struct packed {
        phase_e        ph;
        logic [IW-1:0] idx;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.ph  = PH_RUN;
                    ctl_d.idx = '0;
                    load      = 1'b1;
                end
            end
            PH_RUN: begin
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.ph = PH_FIN;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            PH_FIN: begin
                ctl_d.ph   = PH_IDLE;
                ctl_d.done = 1'b1;
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, idx: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.ph != PH_IDLE);
    assign acc_en = (ctl_q.ph == PH_RUN);
    assign fin    = (ctl_q.ph == PH_FIN);
    assign idx    = ctl_q.idx;
    assign done   = ctl_q.done;

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int                   N_IN  = 4,
    parameter int                   DW    = 8,
    parameter int                   IW    = 2,
    parameter int                   AW    = 20,
    parameter int                   Q     = 4,
    parameter logic [N_IN*DW-1:0]   W_ROW = '0,
    parameter logic [2*DW-1:0]      BIAS  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 acc_en,
    input  logic                 fin,
    input  logic [IW-1:0]        idx,
    input  logic signed [DW-1:0] x_sel,
    output logic signed [DW-1:0] z
);

    localparam logic signed [AW-1:0] POS_ONE = AW'(1) <<< Q;
    localparam logic signed [AW-1:0] NEG_ONE = -POS_ONE;
    localparam logic signed [AW-1:0] BIAS_X  = {{(AW-2*DW){BIAS[2*DW-1]}}, BIAS};

    typedef struct packed {
        logic signed [AW-1:0] acc;
        logic signed [DW-1:0] z;
    } mac_t;

    mac_t mac_d, mac_q;

    logic signed [DW-1:0]   w_sel;
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   biased;
    logic signed [AW-1:0]   scaled;

    always_comb begin
        w_sel  = W_ROW[int'(idx)*DW +: DW];
        prod   = x_sel * w_sel;
        biased = mac_q.acc + BIAS_X;
        scaled = biased >>> Q;
        mac_d  = mac_q;
        if (load) begin
            mac_d.acc = '0;
        end else if (acc_en) begin
            mac_d.acc = mac_q.acc + {{(AW-2*DW){prod[2*DW-1]}}, prod};
        end
        if (fin) begin
            if (scaled > POS_ONE) begin
                mac_d.z = POS_ONE[DW-1:0];
            end else if (scaled < NEG_ONE) begin
                mac_d.z = NEG_ONE[DW-1:0];
            end else begin
                mac_d.z = scaled[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign z = mac_q.z;

endmodule

// File: rtl/mac_layer.sv
module mac_layer #(
    parameter int                          N_IN    = 4,
    parameter int                          N_OUT   = 3,
    parameter int                          DW      = 8,
    parameter int                          Q       = 4,
    parameter logic [N_OUT*N_IN*DW-1:0]    WEIGHTS = 96'h7F807F7F_08E018F0_2004F810,
    parameter logic [N_OUT*2*DW-1:0]       BIASES  = 48'h0000_FF00_0080
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [N_IN*DW-1:0]    in_vec,
    output logic                  busy,
    output logic                  done,
    output logic [N_OUT*DW-1:0]   out_vec
);

    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int AW = 2*DW + $clog2(N_IN + 1) + 2;

    typedef struct packed {
        logic [N_IN-1:0][DW-1:0] x;
    } cap_t;

    cap_t cap_d, cap_q;

    logic          load;
    logic          acc_en;
    logic          fin;
    logic [IW-1:0] idx;
    logic [DW-1:0] x_sel;

    mac_layer_ctrl #(
        .N_IN (N_IN),
        .IW   (IW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .done   (done),
        .load   (load),
        .acc_en (acc_en),
        .fin    (fin),
        .idx    (idx)
    );

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.x = in_vec;
        end
        x_sel = cap_q.x[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_neuron
        logic signed [DW-1:0] z_j;

        mac_unit #(
            .N_IN  (N_IN),
            .DW    (DW),
            .IW    (IW),
            .AW    (AW),
            .Q     (Q),
            .W_ROW (WEIGHTS[j*N_IN*DW +: N_IN*DW]),
            .BIAS  (BIASES[j*2*DW +: 2*DW])
        ) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .acc_en (acc_en),
            .fin    (fin),
            .idx    (idx),
            .x_sel  (x_sel),
            .z      (z_j)
        );

        assign out_vec[j*DW +: DW] = z_j;
    end

endmodule

// File: rtl/mac_layer_chk.sv
module mac_layer_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3,
    parameter int DW    = 8,
    parameter int Q     = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [N_OUT*DW-1:0] out_vec
);

    localparam int CW  = $clog2(N_IN + 2) + 1;
    localparam int LIM = 2 ** Q;

    logic [CW-1:0] busy_cnt;
    logic          all_in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    always_comb begin
        all_in_range = 1'b1;
        for (int j = 0; j < N_OUT; j++) begin
            if (int'($signed(out_vec[j*DW +: DW])) > LIM ||
                int'($signed(out_vec[j*DW +: DW])) < -LIM) begin
                all_in_range = 1'b0;
            end
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R3
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == CW'(N_IN + 1)));

    // R6
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_in_range);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_vec) |-> done);

endmodule

bind mac_layer mac_layer_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .DW    (DW),
    .Q     (Q)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .out_vec (out_vec)
);

// File: tb/tb_mac_layer.sv
module tb_mac_layer;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 4;
    localparam int N_OUT = 3;
    localparam int DW    = 8;
    localparam int Q     = 4;
    localparam logic [N_OUT*N_IN*DW-1:0] W_P = 96'h7F807F7F_08E018F0_2004F810;
    localparam logic [N_OUT*2*DW-1:0]    B_P = 48'h0000_FF00_0080;
    localparam int LIM = 2 ** Q;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [N_IN*DW-1:0]   in_vec = '0;
    logic                 busy;
    logic                 done;
    logic [N_OUT*DW-1:0]  out_vec;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_layer #(
        .N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .Q(Q),
        .WEIGHTS(W_P), .BIASES(B_P)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
        .busy(busy), .done(done), .out_vec(out_vec)
    );

    function automatic int ref_z(int j, logic [N_IN*DW-1:0] xv);
        int y;
        int s;
        y = int'($signed(B_P[j*2*DW +: 2*DW]));
        for (int i = 0; i < N_IN; i++) begin
            y = y + int'($signed(W_P[(j*N_IN+i)*DW +: DW])) * int'($signed(xv[i*DW +: DW]));
        end
        s = y >>> Q;
        if (s > LIM) s = LIM;
        if (s < -LIM) s = -LIM;
        return s;
    endfunction

    function automatic logic [N_IN*DW-1:0] pack4(int a, int b, int c, int d);
        logic [N_IN*DW-1:0] v;
        v[0*DW +: DW] = DW'(a);
        v[1*DW +: DW] = DW'(b);
        v[2*DW +: DW] = DW'(c);
        v[3*DW +: DW] = DW'(d);
        return v;
    endfunction

    function automatic int out_of(int j);
        return int'($signed(out_vec[j*DW +: DW]));
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, cycle by cycle
    logic m_busy = 1'b0;
    logic m_done = 1'b0;
    int   m_rem  = 0;
    int   m_pend [N_OUT];
    int   m_out  [N_OUT];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_rem  <= 0;
            for (int j = 0; j < N_OUT; j++) m_out[j] <= 0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1'b1;
                    m_rem  <= N_IN + 1;
                    for (int j = 0; j < N_OUT; j++) m_pend[j] <= ref_z(j, in_vec);
                end
            end else begin
                if (m_rem == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                    for (int j = 0; j < N_OUT; j++) m_out[j] <= m_pend[j];
                end
                m_rem <= m_rem - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 busy vs model", int'(busy), int'(m_busy));
            check("R3 done vs model", int'(done), int'(m_done));
            for (int j = 0; j < N_OUT; j++) check("R4 out vs model", out_of(j), m_out[j]);
        end
    end

    task automatic run_and_wait(logic [N_IN*DW-1:0] xv, output int lat);
        in_vec = xv;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after accept", int'(busy), 1);
        lat = 0;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic [N_IN*DW-1:0] xa;
        logic [N_IN*DW-1:0] held;

        repeat (3) @(negedge clk);
        check("R1 out in reset", int'(out_vec), 0);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out after reset", int'(out_vec), 0);

        // main function
        xa = pack4(2, 1, 0, -1);
        run_and_wait(xa, lat);
        check("R3 latency", lat, N_IN + 1);
        check("R3 busy low with done", int'(busy), 0);
        for (int j = 0; j < N_OUT; j++) check("R4 neuron result", out_of(j), ref_z(j, xa));
        @(negedge clk);
        check("R3 done single pulse", int'(done), 0);

        // floor rounding
        run_and_wait(pack4(0, 3, 0, -5), lat);
        check("R5 floor negative", out_of(0), -4);
        run_and_wait(pack4(0, 1, 0, 0), lat);
        check("R5 floor positive", out_of(0), 7);

        // clamp
        run_and_wait(pack4(16, 16, -16, 16), lat);
        check("R6 clamp high", out_of(2), LIM);
        run_and_wait(pack4(-16, -16, 16, -16), lat);
        check("R6 clamp low", out_of(2), -LIM);

        // extremes
        xa = pack4(-128, -128, 127, -128);
        run_and_wait(xa, lat);
        for (int j = 0; j < N_OUT; j++) check("R11 extreme neg", out_of(j), ref_z(j, xa));
        xa = pack4(127, 127, -128, 127);
        run_and_wait(xa, lat);
        for (int j = 0; j < N_OUT; j++) check("R11 extreme pos", out_of(j), ref_z(j, xa));

        // start while busy ignored, inputs changed while busy ignored
        @(negedge clk);
        xa = pack4(3, -2, 5, 1);
        in_vec = xa;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        in_vec = pack4(-7, 9, -3, 4);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        in_vec = pack4(100, -100, 50, -50);
        while (!done) @(negedge clk);
        for (int j = 0; j < N_OUT; j++) check("R7 R8 captured result", out_of(j), ref_z(j, xa));
        @(negedge clk);
        check("R7 no second run", int'(busy), 0);

        // outputs hold while idle
        held = out_vec;
        for (int k = 0; k < N_IN + 4; k++) begin
            in_vec = pack4(k, -k, 2*k, 1);
            @(negedge clk);
            check("R9 no done while idle", int'(done), 0);
        end
        check("R9 out held", int'(out_vec == held), 1);

        // back to back start on the done cycle
        xa = pack4(1, 1, 1, 1);
        run_and_wait(xa, lat);
        xa = pack4(-3, 4, -2, 6);
        in_vec = xa;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 accepted on done cycle", int'(busy), 1);
        while (!done) @(negedge clk);
        for (int j = 0; j < N_OUT; j++) check("R10 back to back result", out_of(j), ref_z(j, xa));

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule